// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block holds recently used virtual-to-physical page translations for a 32-bit core that uses 4 KB pages. Each cycle a requester may present a virtual address and the current address space identifier (ASID). When translation is on, the block answers in the same cycle. A hit returns the physical address and the stored permission bits. A miss tells the requester to start a page walk. The walk result comes back through a fill port and is written into a slot. A mode input turns translation off. The address then passes straight through and no lookup is reported.

Each slot keeps a physical page number, six permission bits, a global flag, an ASID and a tag. A parameter sets the number of ways to one (direct-mapped) or two (set-associative). In the 2-way form, a one-bit least-recently-used marker per set picks the way to replace. An invalidation port removes entries in four ways: by page and ASID, by page only, by ASID only, or all entries. An invalidation always wins over a fill in the same cycle.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is empty: any lookup with translation on reports a miss, no hit and all-zero permissions.
- R2: A filled translation hits in the same cycle it is looked up, from the clock edge after the fill onward. `lk_paddr` is then {stored physical page number, 12-bit offset} and `lk_perm` returns the stored bits {D,A,U,X,W,R} (bit 5 down to bit 0). `lk_hit` and `lk_miss` are both low when `lk_req` is low, and exactly one is high when `lk_req` and `xlat_en` are high.
- R3: A hit needs both the tag and the ASID to match. A matching page under another ASID misses, unless the entry was filled with `fill_glb` high, in which case any ASID matches.
- R4: With `xlat_en` low, `lk_paddr` equals `lk_vaddr`, and `lk_hit` and `lk_miss` both stay low.
- R5: In the 2-way form, a fill into a set with a free way uses the free way, so both translations stay resident.
- R6: In the 2-way form, a fill into a full set replaces the way that was least recently hit or filled.
- R7: `inv_mode` = 2'b11 removes non-global entries whose page and ASID both equal the command. Global entries and other ASIDs stay.
- R8: `inv_mode` = 2'b10 removes every entry for the given page under any ASID, global ones included. Other pages stay.
- R9: `inv_mode` = 2'b01 removes every non-global entry with the given ASID. Global entries and other ASIDs stay.
- R10: `inv_mode` = 2'b00 removes all entries.
- R11: An invalidation takes effect at the next clock edge and, in the same cycle, suppresses any fill.
- R12: The low 12 bits of `lk_paddr` always equal the low 12 bits of `lk_vaddr`.
- R13: In the direct-mapped form, a fill to a page that shares a set index (virtual address bits 14:12 at default size) replaces the resident entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | 1 = translate, 0 = pass address through |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | ASID of the lookup |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation not present |
| lk_paddr | output | PPN_W+12 | Physical address |
| lk_perm | output | 6 | Permission bits {D,A,U,X,W,R} of the hit |
| fill_en | input | 1 | Write a walk result |
| fill_vpn | input | VA_W-12 | Virtual page number of the fill |
| fill_asid | input | ASID_W | ASID of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_perm | input | 6 | Permission bits of the fill |
| fill_glb | input | 1 | Fill is a global mapping |
| inv_en | input | 1 | Invalidation command |
| inv_mode | input | 2 | 00 all, 01 ASID, 10 page, 11 page+ASID |
| inv_vpn | input | VA_W-12 | Page for page-based invalidation |
| inv_asid | input | ASID_W | ASID for ASID-based invalidation |

## Verification
The bench fills two pages into one set of both a 2-way and a direct-mapped instance. It then checks that the direct-mapped copy lost the first page while the 2-way copy kept both. A replacement policy that ignored recency, or picked an occupied way over a free one, would drop the wrong page. Global entries are placed beside ordinary ones in every invalidation test. An ASID-based flush that forgot the global flag would remove them, and a page-only flush that honoured it would leave a stale mapping behind. A flush issued together with a fill must leave that fill absent; a design that lets the fill win would then hit on it.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    localparam int PG_OFF_W = 12;
    localparam int PERM_W   = 6;

    typedef enum logic [1:0] {
        INV_ALL     = 2'b00,
        INV_ASID    = 2'b01,
        INV_VA      = 2'b10,
        INV_VA_ASID = 2'b11
    } inv_mode_e;

    // Decide whether one valid slot is removed by an invalidation command.
    function automatic logic inv_kill(input inv_mode_e mode, input logic vpn_eq,
                                      input logic asid_eq, input logic glb);
        logic k;
        case (mode)
            INV_ALL:     k = 1'b1;
            INV_ASID:    k = asid_eq & ~glb;
            INV_VA:      k = vpn_eq;
            default:     k = vpn_eq & asid_eq & ~glb;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/asid_tlb_cmp.sv
module asid_tlb_cmp #(
    parameter int TAG_W  = 17,
    parameter int ASID_W = 9
) (
    input  logic              vld,
    input  logic              glb,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ASID_W-1:0] req_asid,
    output logic              match
);
    always_comb begin
        match = vld && (ent_tag == req_tag) && (glb || (ent_asid == req_asid));
    end
endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  vld,
    input  logic             lru,
    output logic [WAY_W-1:0] way
);
    generate
        if (WAYS == 1) begin : g_dm
            always_comb way = '0;
        end else begin : g_2w
            always_comb begin
                if (!vld[0])      way = WAY_W'(0);
                else if (!vld[1]) way = WAY_W'(1);
                else              way = WAY_W'(lru);
            end
        end
    endgenerate
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PPN_W  = 20,
    parameter int ASID_W = 9,
    parameter int SETS   = 8,
    parameter int WAYS   = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       xlat_en,
    input  logic                       lk_req,
    input  logic [VA_W-1:0]            lk_vaddr,
    input  logic [ASID_W-1:0]          lk_asid,
    output logic                       lk_hit,
    output logic                       lk_miss,
    output logic [PPN_W+PG_OFF_W-1:0]  lk_paddr,
    output logic [PERM_W-1:0]          lk_perm,
    input  logic                       fill_en,
    input  logic [VA_W-PG_OFF_W-1:0]   fill_vpn,
    input  logic [ASID_W-1:0]          fill_asid,
    input  logic [PPN_W-1:0]           fill_ppn,
    input  logic [PERM_W-1:0]          fill_perm,
    input  logic                       fill_glb,
    input  logic                       inv_en,
    input  logic [1:0]                 inv_mode,
    input  logic [VA_W-PG_OFF_W-1:0]   inv_vpn,
    input  logic [ASID_W-1:0]          inv_asid
);
    localparam int VPN_W = VA_W - PG_OFF_W;
    localparam int PA_W  = PPN_W + PG_OFF_W;
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic              glb;
        logic [ASID_W-1:0] asid;
        logic [TAG_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } ent_t;

    ent_t            ent_q [SETS][WAYS];
    logic [WAYS-1:0] vld_q [SETS];
    logic            lru_q [SETS];

    // ---------------- lookup ----------------
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  way_hit;
    logic [WAY_W-1:0] hit_way;
    ent_t             hit_ent;
    logic             any_hit;

    assign lk_idx = lk_vaddr[PG_OFF_W +: IDX_W];
    assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            asid_tlb_cmp #(.TAG_W(TAG_W), .ASID_W(ASID_W)) u_cmp (
                .vld      (vld_q[lk_idx][w]),
                .glb      (ent_q[lk_idx][w].glb),
                .ent_tag  (ent_q[lk_idx][w].tag),
                .ent_asid (ent_q[lk_idx][w].asid),
                .req_tag  (lk_tag),
                .req_asid (lk_asid),
                .match    (way_hit[w])
            );
        end
    endgenerate

    always_comb begin
        hit_way = '0;
        hit_ent = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                hit_way = WAY_W'(w);
                hit_ent = ent_q[lk_idx][w];
            end
        end
        any_hit = |way_hit;
    end

    always_comb begin
        lk_hit   = xlat_en && lk_req && any_hit;
        lk_miss  = xlat_en && lk_req && !any_hit;
        lk_perm  = lk_hit ? hit_ent.perm : '0;
        if (xlat_en)
            lk_paddr = {(lk_hit ? hit_ent.ppn : {PPN_W{1'b0}}), lk_vaddr[PG_OFF_W-1:0]};
        else
            lk_paddr = PA_W'(lk_vaddr);
    end

    // ---------------- fill ----------------
    logic [IDX_W-1:0] fill_idx;
    logic [WAY_W-1:0] vic_way;
    ent_t             fill_ent;

    assign fill_idx = fill_vpn[IDX_W-1:0];
    assign fill_ent = '{glb: fill_glb, asid: fill_asid, tag: fill_vpn[VPN_W-1 -: TAG_W],
                        ppn: fill_ppn, perm: fill_perm};

    asid_tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_vic (
        .vld (vld_q[fill_idx]),
        .lru (lru_q[fill_idx]),
        .way (vic_way)
    );

    logic do_fill;
    assign do_fill = fill_en && !inv_en;

    // ---------------- invalidation ----------------
    logic [WAYS-1:0] kill [SETS];

    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                kill[s][w] = inv_en && vld_q[s][w] &&
                    inv_kill(inv_mode_e'(inv_mode),
                             {ent_q[s][w].tag, IDX_W'(s)} == inv_vpn,
                             ent_q[s][w].asid == inv_asid,
                             ent_q[s][w].glb);
            end
        end
    end

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                lru_q[s] <= 1'b0;
            end
        end else begin
            if (lk_hit && WAYS > 1)
                lru_q[lk_idx] <= ~hit_way[0];
            if (inv_en) begin
                for (int s = 0; s < SETS; s++)
                    vld_q[s] <= vld_q[s] & ~kill[s];
            end else if (do_fill) begin
                vld_q[fill_idx][vic_way] <= 1'b1;
                if (WAYS > 1)
                    lru_q[fill_idx] <= ~vic_way[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_fill)
            ent_q[fill_idx][vic_way] <= fill_ent;
    end

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
    parameter int VA_W   = 32,
    parameter int PPN_W  = 20,
    parameter int ASID_W = 9
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  xlat_en,
    input logic                  lk_req,
    input logic [VA_W-1:0]       lk_vaddr,
    input logic                  lk_hit,
    input logic                  lk_miss,
    input logic [PPN_W+11:0]     lk_paddr,
    input logic                  inv_en,
    input logic [1:0]            inv_mode,
    input logic [VA_W-13:0]      inv_vpn
);
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !lk_hit); // R1
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        (lk_req && xlat_en) |-> (lk_hit != lk_miss)); // R2
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !lk_req |-> (!lk_hit && !lk_miss)); // R2
    AST_BYPASS_ADDR: assert property (@(posedge clk) disable iff (rst)
        !xlat_en |-> (!lk_hit && !lk_miss && lk_paddr == (PPN_W+12)'(lk_vaddr))); // R4
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        lk_paddr[11:0] == lk_vaddr[11:0]); // R12
    AST_PAGE_GONE: assert property (@(posedge clk) disable iff (rst)
        (inv_en && inv_mode == 2'b10) |=>
        !(lk_hit && lk_vaddr[VA_W-1:12] == $past(inv_vpn))); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (inv_en && inv_mode == 2'b00) |=> !lk_hit); // R10 R11
endmodule

bind asid_tlb asid_tlb_chk #(.VA_W(VA_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) u_chk (.*);

// File: tb/asid_tlb_tb.sv
`timescale 1ns/1ps
module asid_tlb_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        xlat_en, lk_req;
    logic [31:0] lk_vaddr;
    logic [8:0]  lk_asid;
    logic        fill_en, fill_glb, inv_en;
    logic [19:0] fill_vpn, fill_ppn, inv_vpn;
    logic [8:0]  fill_asid, inv_asid;
    logic [5:0]  fill_perm;
    logic [1:0]  inv_mode;

    logic        a_hit, a_miss, d_hit, d_miss;
    logic [31:0] a_pa, d_pa;
    logic [5:0]  a_perm, d_perm;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic        g_hit, g_miss, g_dhit;
    logic [31:0] g_pa;
    logic [5:0]  g_perm;

    always #2.5 clk = ~clk;

    asid_tlb #(.WAYS(2)) dut_i (
        .clk(clk), .rst(rst), .xlat_en(xlat_en), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_hit(a_hit), .lk_miss(a_miss), .lk_paddr(a_pa), .lk_perm(a_perm),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_ppn(fill_ppn),
        .fill_perm(fill_perm), .fill_glb(fill_glb), .inv_en(inv_en), .inv_mode(inv_mode),
        .inv_vpn(inv_vpn), .inv_asid(inv_asid));

    asid_tlb #(.WAYS(1)) dut_dm (
        .clk(clk), .rst(rst), .xlat_en(xlat_en), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_hit(d_hit), .lk_miss(d_miss), .lk_paddr(d_pa), .lk_perm(d_perm),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_ppn(fill_ppn),
        .fill_perm(fill_perm), .fill_glb(fill_glb), .inv_en(inv_en), .inv_mode(inv_mode),
        .inv_vpn(inv_vpn), .inv_asid(inv_asid));

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; xlat_en = 1; lk_req = 0; lk_vaddr = '0; lk_asid = '0;
        fill_en = 0; fill_vpn = '0; fill_asid = '0; fill_ppn = '0; fill_perm = '0; fill_glb = 0;
        inv_en = 0; inv_mode = '0; inv_vpn = '0; inv_asid = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
    endtask

    task automatic look(input logic [19:0] vpn, input logic [8:0] asid,
                        input logic [11:0] off, input logic x);
        @(negedge clk);
        xlat_en = x; lk_req = 1; lk_vaddr = {vpn, off}; lk_asid = asid;
        #1;
        g_hit = a_hit; g_miss = a_miss; g_pa = a_pa; g_perm = a_perm; g_dhit = d_hit;
        @(posedge clk); #1;
        lk_req = 0; xlat_en = 1;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [8:0] asid,
                        input logic [19:0] ppn, input logic [5:0] perm, input logic glb);
        @(negedge clk);
        fill_en = 1; fill_vpn = vpn; fill_asid = asid; fill_ppn = ppn;
        fill_perm = perm; fill_glb = glb;
        @(posedge clk); #1;
        fill_en = 0;
    endtask

    task automatic inv(input logic [1:0] mode, input logic [19:0] vpn, input logic [8:0] asid);
        @(negedge clk);
        inv_en = 1; inv_mode = mode; inv_vpn = vpn; inv_asid = asid;
        @(posedge clk); #1;
        inv_en = 0;
    endtask

    task automatic t_reset();
        do_reset();
        look(20'h00000, 9'd0, 12'h000, 1);
        chk("R1", "miss", g_miss, 1); chk("R1", "hit", g_hit, 0); chk("R1", "perm", g_perm, 0);
        look(20'hFFFFF, 9'd3, 12'h123, 1);
        chk("R1", "miss2", g_miss, 1);
    endtask

    task automatic t_hit_basic();
        do_reset();
        fill(20'h00012, 9'd1, 20'hABCDE, 6'b110011, 0);
        look(20'h00012, 9'd1, 12'h5A7, 1);
        chk("R2", "hit", g_hit, 1); chk("R2", "miss", g_miss, 0);
        chk("R2", "paddr", g_pa, 32'hABCDE5A7); chk("R2", "perm", g_perm, 6'b110011);
        look(20'h00012, 9'd1, 12'hFFF, 1);
        chk("R12", "offset", g_pa, 32'hABCDEFFF);
    endtask

    task automatic t_asid();
        do_reset();
        fill(20'h00020, 9'd5, 20'h0ABCD, 6'b001111, 0);
        look(20'h00020, 9'd5, 12'h0, 1); chk("R3", "same asid hit", g_hit, 1);
        look(20'h00020, 9'd6, 12'h0, 1); chk("R3", "other asid miss", g_miss, 1);
        fill(20'h00033, 9'd2, 20'h12345, 6'b000001, 1);
        look(20'h00033, 9'd7, 12'h0, 1); chk("R3", "global any asid", g_hit, 1);
        chk("R3", "global paddr", g_pa, 32'h12345000);
    endtask

    task automatic t_bypass();
        do_reset();
        fill(20'h12345, 9'd1, 20'h00777, 6'b000011, 0);
        look(20'h12345, 9'd1, 12'h678, 0);
        chk("R4", "hit", g_hit, 0); chk("R4", "miss", g_miss, 0);
        chk("R4", "paddr", g_pa, 32'h12345678);
    endtask

    task automatic t_ways();
        do_reset();
        fill(20'h00001, 9'd1, 20'h00111, 6'b1, 0);
        fill(20'h00009, 9'd1, 20'h00222, 6'b1, 0);
        look(20'h00009, 9'd1, 12'h0, 1);
        chk("R5", "second way hit", g_hit, 1); chk("R5", "second ppn", g_pa, 32'h00222000);
        look(20'h00001, 9'd1, 12'h0, 1);
        chk("R5", "first way kept", g_hit, 1); chk("R5", "first ppn", g_pa, 32'h00111000);
        chk("R13", "dm evicted first", g_dhit, 0);
        fill(20'h00011, 9'd1, 20'h00333, 6'b1, 0);
        look(20'h00009, 9'd1, 12'h0, 1); chk("R6", "lru victim gone", g_hit, 0);
        look(20'h00001, 9'd1, 12'h0, 1); chk("R6", "recent kept", g_hit, 1);
        look(20'h00011, 9'd1, 12'h0, 1); chk("R6", "new present", g_hit, 1);
        chk("R13", "dm holds latest", g_dhit, 1);
        fill(20'h00019, 9'd1, 20'h00444, 6'b1, 0);
        look(20'h00001, 9'd1, 12'h0, 1); chk("R6", "older hit evicted", g_hit, 0);
        look(20'h00011, 9'd1, 12'h0, 1); chk("R6", "last hit kept", g_hit, 1);
    endtask

    task automatic t_inv_va_asid();
        do_reset();
        fill(20'h00042, 9'd3, 20'h00001, 6'b1, 0);
        fill(20'h00042, 9'd4, 20'h00002, 6'b1, 0);
        fill(20'h00043, 9'd3, 20'h00003, 6'b1, 1);
        inv(2'b11, 20'h00042, 9'd3);
        inv(2'b11, 20'h00043, 9'd3);
        look(20'h00042, 9'd3, 12'h0, 1); chk("R7", "target removed", g_hit, 0);
        look(20'h00042, 9'd4, 12'h0, 1); chk("R7", "other asid kept", g_pa, 32'h00002000);
        look(20'h00043, 9'd3, 12'h0, 1); chk("R7", "global kept", g_hit, 1);
    endtask

    task automatic t_inv_va();
        do_reset();
        fill(20'h00042, 9'd3, 20'h00001, 6'b1, 0);
        fill(20'h00042, 9'd4, 20'h00002, 6'b1, 0);
        fill(20'h00043, 9'd3, 20'h00003, 6'b1, 1);
        fill(20'h00044, 9'd3, 20'h00004, 6'b1, 0);
        inv(2'b10, 20'h00042, 9'd0);
        inv(2'b10, 20'h00043, 9'd9);
        look(20'h00042, 9'd3, 12'h0, 1); chk("R8", "asid3 removed", g_hit, 0);
        look(20'h00042, 9'd4, 12'h0, 1); chk("R8", "asid4 removed", g_hit, 0);
        look(20'h00043, 9'd3, 12'h0, 1); chk("R8", "global removed", g_hit, 0);
        look(20'h00044, 9'd3, 12'h0, 1); chk("R8", "other page kept", g_hit, 1);
    endtask

    task automatic t_inv_asid();
        do_reset();
        fill(20'h00050, 9'd9,  20'h00010, 6'b1, 0);
        fill(20'h00061, 9'd9,  20'h00011, 6'b1, 0);
        fill(20'h00052, 9'd10, 20'h00012, 6'b1, 0);
        fill(20'h00053, 9'd9,  20'h00013, 6'b1, 1);
        inv(2'b01, 20'h0, 9'd9);
        look(20'h00050, 9'd9, 12'h0, 1);  chk("R9", "asid9 a removed", g_hit, 0);
        look(20'h00061, 9'd9, 12'h0, 1);  chk("R9", "asid9 b removed", g_hit, 0);
        look(20'h00052, 9'd10, 12'h0, 1); chk("R9", "asid10 kept", g_hit, 1);
        look(20'h00053, 9'd9, 12'h0, 1);  chk("R9", "global kept", g_hit, 1);
    endtask

    task automatic t_inv_all();
        do_reset();
        fill(20'h00070, 9'd1, 20'h00020, 6'b1, 0);
        fill(20'h00071, 9'd2, 20'h00021, 6'b1, 1);
        inv(2'b00, 20'h0, 9'd0);
        look(20'h00070, 9'd1, 12'h0, 1); chk("R10", "plain removed", g_hit, 0);
        look(20'h00071, 9'd2, 12'h0, 1); chk("R10", "global removed", g_hit, 0);
    endtask

    task automatic t_prio();
        do_reset();
        @(negedge clk);
        inv_en = 1; inv_mode = 2'b00; fill_en = 1; fill_vpn = 20'h00075;
        fill_asid = 9'd1; fill_ppn = 20'h00055; fill_perm = 6'b1; fill_glb = 0;
        @(posedge clk); #1;
        inv_en = 0; fill_en = 0;
        look(20'h00075, 9'd1, 12'h0, 1); chk("R11", "fill suppressed", g_hit, 0);
        fill(20'h00075, 9'd1, 20'h00055, 6'b1, 0);
        look(20'h00075, 9'd1, 12'h0, 1); chk("R11", "later fill lands", g_hit, 1);
    endtask

    initial begin
        t_reset();
        t_hit_basic();
        t_asid();
        t_bypass();
        t_ways();
        t_inv_va_asid();
        t_inv_va();
        t_inv_asid();
        t_inv_all();
        t_prio();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule